// File: doc/BRIEF.md
# Write-Strobe Burst Engine

This block sends a burst of bytes over an 8-bit parallel display bus. It paces the transfer with its own active-low write strobe. A period counter makes one strobe pulse per byte. The strobe is low for the first part of each period and high for the rest. The receiver latches on the strobe's rising edge. The next byte is not loaded at the edge but at a later fetch point inside the high phase. The new value therefore has the rest of that period and the next low phase to settle before the next latch.

A burst begins with a start pulse that carries a byte count minus one (1 to 256 bytes). The engine first takes byte 0 from its ready/valid input and places it on the bus, and only then starts the counter. It stops by itself after the last pulse. It reports completion only once the counter has stopped and every byte of the burst has been taken. If the source runs dry at a fetch point, the engine holds the strobe high and waits.

Top module: `strobe_burst_engine`

## Requirements
- R1: After reset, wrN is 1, busData is 0, and busy, done, inReady and underrun are all 0.
- R2: During a burst, every strobe period is PERIOD+1 cycles long (default 12). wrN is 0 while the period count is below LOW_TICKS (default 6) and 1 from LOW_TICKS up to PERIOD. The exception is a stalled period, which is lengthened as R10 describes.
- R3: Byte 0 is taken and driven onto busData before the counter starts. Each rising edge of wrN presents the burst's bytes in the order the input delivered them.
- R4: After byte 0, the input is read only at period count FETCH_AT (default 8, inside the high phase). busData never changes while wrN stays low, and inReady is never 1 while wrN is 0.
- R5: A burst started with lenM1 = L gives exactly L+1 rising edges of wrN and takes exactly L+1 bytes from the input, for every L from 0 to 255.
- R6: In a one-byte burst (lenM1 = 0), no byte is requested after byte 0, even when the source still holds valid data.
- R7: While the engine is idle, inReady is 0, so a byte waiting on the input is left where it is and cannot slip into the next burst.
- R8: done is 1 for exactly one cycle, in the cycle after the final period's count reaches PERIOD. busy is 1 from the cycle after start through that done cycle, and 0 otherwise.
- R9: Between bursts, wrN stays 1 and busData keeps the last byte of the previous burst.
- R10: If no valid byte is present at a fetch point, the count holds at FETCH_AT, wrN stays 1 and underrun is 1. The engine resumes when a byte arrives.
- R11: A start pulse that arrives while busy is 1 is ignored, and the burst length of the running burst does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a burst when the engine is idle |
| lenM1 | input | 8 | Burst length minus one, sampled on start |
| inData | input | 8 | Input byte |
| inValid | input | 1 | Input byte is valid |
| inReady | output | 1 | The engine accepts the input byte in this cycle |
| busData | output | 8 | Parallel data bus |
| wrN | output | 1 | Active-low write strobe; the receiver latches on its rising edge |
| busy | output | 1 | A burst is in progress |
| done | output | 1 | One-cycle burst completion pulse |
| underrun | output | 1 | Stalled at a fetch point waiting for a byte |

## Verification
Some properties are checked by assertions on every cycle:
- the bus holds still through each low phase;
- no fetch happens while the strobe is low;
- the count freezes during an underrun, and the strobe stays high while it does;
- done lasts a single cycle;
- busy falls only right after done.

Other properties can only be shown by the bench's scenarios:
- the latched byte order;
- the exact pulse and byte counts for lengths 1, 3, 4, 5 and 256;
- the single-byte burst that leaves a waiting byte untouched;
- the ignored start during a burst;
- the recovery from an underrun.

The bench checks these against a behavioural model of the count, the state and the byte queues.

// File: rtl/sbe_pkg.sv
package sbe_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PRIME = 2'd1,
    ST_RUN   = 2'd2,
    ST_DONE  = 2'd3
  } engState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadBus;    // capture inData onto the bus this edge
    logic strobeLow;  // drive the write strobe low
  } dpCtrl_t;

endpackage

// File: rtl/sbe_ctrl.sv
module sbe_ctrl
  import sbe_pkg::*;
#(
  parameter int PERIOD    = 11,
  parameter int LOW_TICKS = 6,
  parameter int FETCH_AT  = 8,
  parameter int LEN_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LEN_W-1:0] lenM1,
  input  logic             inValid,
  output logic             inReady,
  output logic             busy,
  output logic             done,
  output logic             underrun,
  output dpCtrl_t          dpCtrl
);

  localparam int CNT_W = $clog2(PERIOD + 1);
  localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(PERIOD);
  localparam logic [CNT_W-1:0] LOW_C   = CNT_W'(LOW_TICKS);
  localparam logic [CNT_W-1:0] FETCH_C = CNT_W'(FETCH_AT);

  engState_t        state;
  logic [CNT_W-1:0] cnt;
  logic [LEN_W-1:0] remain;   // pulses still to come after the current one
  logic             atFetch;
  logic             take;

  always_comb begin
    atFetch          = (state == ST_RUN) && (cnt == FETCH_C) && (remain != '0);
    inReady          = (state == ST_PRIME) || atFetch;
    take             = inReady && inValid;
    underrun         = atFetch && !inValid;
    busy             = (state != ST_IDLE);
    done             = (state == ST_DONE);
    dpCtrl.loadBus   = take;
    dpCtrl.strobeLow = (state == ST_RUN) && (cnt < LOW_C);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      remain <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state  <= ST_PRIME;
            remain <= lenM1;
          end
        end
        ST_PRIME: begin
          if (inValid) begin
            state <= ST_RUN;
            cnt   <= '0;
          end
        end
        ST_RUN: begin
          if (atFetch) begin
            if (inValid) cnt <= cnt + CNT_W'(1);
          end else if (cnt == LAST_C) begin
            if (remain == '0) begin
              state <= ST_DONE;
            end else begin
              remain <= remain - LEN_W'(1);
              cnt    <= '0;
            end
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_NO_FETCH_LOW: assert property (@(posedge clk) disable iff (!rstN)
    dpCtrl.strobeLow |-> !inReady); // R4

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    underrun |=> $stable(cnt)); // R10

  AST_STALL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    underrun |-> !dpCtrl.strobeLow); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8

  AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(done)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !inReady); // R7

endmodule

// File: rtl/sbe_datapath.sv
module sbe_datapath
  import sbe_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dpCtrl,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] busData,
  output logic              wrN
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               busData <= '0;
    else if (dpCtrl.loadBus) busData <= inData;
  end

  assign wrN = ~dpCtrl.strobeLow;

  AST_BUS_STEADY_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (!wrN && $past(!wrN)) |-> $stable(busData)); // R4

  AST_NO_LOAD_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> !dpCtrl.loadBus); // R4

endmodule

// File: rtl/strobe_burst_engine.sv
module strobe_burst_engine
  import sbe_pkg::*;
#(
  parameter int PERIOD    = 11,
  parameter int LOW_TICKS = 6,
  parameter int FETCH_AT  = 8,
  parameter int LEN_W     = 8,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [LEN_W-1:0]  lenM1,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  output logic [DATA_W-1:0] busData,
  output logic              wrN,
  output logic              busy,
  output logic              done,
  output logic              underrun
);

  dpCtrl_t dpCtrl;

  sbe_ctrl #(
    .PERIOD   (PERIOD),
    .LOW_TICKS(LOW_TICKS),
    .FETCH_AT (FETCH_AT),
    .LEN_W    (LEN_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .lenM1   (lenM1),
    .inValid (inValid),
    .inReady (inReady),
    .busy    (busy),
    .done    (done),
    .underrun(underrun),
    .dpCtrl  (dpCtrl)
  );

  sbe_datapath #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .dpCtrl (dpCtrl),
    .inData (inData),
    .busData(busData),
    .wrN    (wrN)
  );

endmodule

// File: tb/strobe_burst_engine_bench.sv
module strobe_burst_engine_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PER = 11;
  localparam int LOW = 6;
  localparam int FET = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [7:0] lenM1 = '0;
  logic [7:0] inData = '0;
  logic       inValid = 1'b0;
  logic       inReady, wrN, busy, done, underrun;
  logic [7:0] busData;

  strobe_burst_engine u_strobe_burst_engine (
    .clk(clk), .rstN(rstN), .start(start), .lenM1(lenM1),
    .inData(inData), .inValid(inValid), .inReady(inReady),
    .busData(busData), .wrN(wrN), .busy(busy), .done(done),
    .underrun(underrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0] srcQ[$];
  logic [7:0] expQ[$];
  logic [7:0] latQ[$];
  int checks = 0;
  int errors = 0;
  int mState = 0;
  int mCnt = 0;
  int mRem = 0;
  logic [7:0] mBus = '0;
  logic prevWr = 1'b1;
  bit   startReq = 0;
  int takenCount, pulseCount, doneCount, underCount;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One clock: advance the model over the edge just passed, drive, compare.
  task automatic tick();
    bit took;
    bit fetchPt;
    @(negedge clk);
    took = 0;
    if (!rstN) begin
      mState = 0; mCnt = 0; mRem = 0; mBus = '0;
    end else begin
      case (mState)
        0: if (start) begin mState = 1; mRem = lenM1; end
        1: if (inValid) begin mBus = inData; mState = 2; mCnt = 0; took = 1; end
        2: begin
          if (mCnt == FET && mRem != 0) begin
            if (inValid) begin mBus = inData; mCnt++; took = 1; end
          end else if (mCnt == PER) begin
            if (mRem == 0) mState = 3;
            else begin mRem--; mCnt = 0; end
          end else mCnt++;
        end
        default: mState = 0;
      endcase
    end
    if (took) begin
      void'(srcQ.pop_front());
      takenCount++;
    end
    start = startReq;
    startReq = 0;
    if (srcQ.size() > 0) begin inValid = 1'b1; inData = srcQ[0]; end
    else inValid = 1'b0;
    #1;
    fetchPt = (mState == 2) && (mCnt == FET) && (mRem != 0);
    chk(wrN == !((mState == 2) && (mCnt < LOW)), "R2", "wrN", wrN, !((mState == 2) && (mCnt < LOW)));
    chk(busData == mBus, "R3", "busData", busData, mBus);
    chk(busy == (mState != 0), "R8", "busy", busy, mState != 0);
    chk(done == (mState == 3), "R8", "done", done, mState == 3);
    chk(inReady == ((mState == 1) || fetchPt), "R4", "inReady", inReady, (mState == 1) || fetchPt);
    chk(underrun == (fetchPt && !inValid), "R10", "underrun", underrun, fetchPt && !inValid);
    if (!prevWr && wrN) begin
      latQ.push_back(busData);
      pulseCount++;
    end
    if (done) doneCount++;
    if (underrun) underCount++;
    prevWr = wrN;
  endtask

  task automatic push(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      srcQ.push_back(8'(base + i * 7));
      expQ.push_back(8'(base + i * 7));
    end
  endtask

  task automatic startBurst(input int n);
    takenCount = 0; pulseCount = 0; doneCount = 0; underCount = 0;
    latQ.delete();
    lenM1 = 8'(n - 1);
    startReq = 1;
    tick();
  endtask

  task automatic waitIdle();
    int guard = 0;
    tick();
    while (mState != 0 && guard < 10000) begin
      tick();
      guard++;
    end
  endtask

  task automatic checkLatched(input string req);
    chk(latQ.size() == expQ.size(), req, "latched count", latQ.size(), expQ.size());
    for (int i = 0; i < latQ.size() && i < expQ.size(); i++)
      chk(latQ[i] == expQ[i], req, "latched byte", latQ[i], expQ[i]);
    expQ.delete();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    // R1: reset state
    chk(wrN == 1'b1 && busy == 1'b0 && done == 1'b0 && inReady == 1'b0 &&
        underrun == 1'b0 && busData == 8'h00, "R1", "reset outputs", busData, 0);
    rstN = 1'b1;
    repeat (2) tick();

    // R2 R3 R5: four bytes, source always ready
    push(4, 8'h10);
    startBurst(4);
    waitIdle();
    chk(pulseCount == 4, "R5", "pulses", pulseCount, 4);
    chk(takenCount == 4, "R5", "bytes taken", takenCount, 4);
    chk(doneCount == 1, "R8", "done cycles", doneCount, 1);
    checkLatched("R3");

    // R9: idle holds the last byte with wrN high
    repeat (8) tick();
    chk(busData == 8'(8'h10 + 21), "R9", "idle bus", busData, 8'(8'h10 + 21));
    chk(wrN == 1'b1, "R9", "idle wrN", wrN, 1);

    // R6: one-byte burst with a spare byte waiting
    push(1, 8'hA0);
    srcQ.push_back(8'hEE);
    startBurst(1);
    waitIdle();
    chk(takenCount == 1, "R6", "bytes taken", takenCount, 1);
    chk(srcQ.size() == 1, "R6", "spare left", srcQ.size(), 1);
    chk(pulseCount == 1, "R6", "pulses", pulseCount, 1);
    checkLatched("R6");

    // R7: a valid byte waiting while idle is not consumed
    repeat (10) tick();
    chk(srcQ.size() == 1, "R7", "idle spare kept", srcQ.size(), 1);
    chk(busData == 8'hA0, "R7", "idle bus unchanged", busData, 8'hA0);
    srcQ.delete();
    tick();

    // R10: source runs dry mid-burst
    push(2, 8'h30);
    startBurst(5);
    repeat (60) tick();
    chk(underCount > 0, "R10", "underrun seen", underCount, 1);
    chk(wrN == 1'b1 && underrun == 1'b1, "R10", "stalled high", wrN, 1);
    chk(pulseCount == 2, "R10", "pulses before refill", pulseCount, 2);
    push(3, 8'h60);
    waitIdle();
    chk(pulseCount == 5, "R10", "pulses after refill", pulseCount, 5);
    checkLatched("R10");

    // R11: start during a burst is ignored
    push(3, 8'h05);
    startBurst(3);
    repeat (5) tick();
    lenM1 = 8'd200;
    startReq = 1;
    tick();
    waitIdle();
    chk(pulseCount == 3, "R11", "pulses", pulseCount, 3);
    chk(takenCount == 3, "R11", "bytes taken", takenCount, 3);
    checkLatched("R11");
    repeat (4) tick();
    chk(busy == 1'b0, "R11", "busy after", busy, 0);

    // R5: full 256-byte burst
    push(256, 8'h01);
    startBurst(256);
    waitIdle();
    chk(pulseCount == 256, "R5", "pulses 256", pulseCount, 256);
    chk(takenCount == 256, "R5", "bytes 256", takenCount, 256);
    chk(doneCount == 1, "R8", "done cycles 256", doneCount, 1);
    checkLatched("R5");

    repeat (4) tick();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule